// File: doc/BRIEF.md
# Chroma Horizontal Edge-Offset Filter

This block applies horizontal edge-class sample-adaptive-offset correction to 8-bit chroma whose two components arrive interleaved as (U, V) byte pairs. Each pair in a row is taken in once, one pair per clock, over a valid/ready stream. Every component is compared with the same component in the pair to its left and the pair to its right. The result of those two comparisons picks an edge category. A signed offset for that category is looked up from a table of its own for each component, added to the sample, and the sum is clipped to 0..255. The filtered pair leaves on a registered output stream.

The block also keeps three pieces of neighbour context for the next block. A left-column store holds one unfiltered pair per row. Software can load it before a block, and the block rewrites each row's entry with that row's last unfiltered pair. A top-row store takes the unfiltered pairs of the block's last row. A top-left register takes the last pair of the previous top row at the start of each block.

A three-state controller sequences every row. In `ST_HEAD` it waits for the first pair of the row. In `ST_BODY` it takes the interior pairs and emits one filtered pair for each. In `ST_TAIL` it waits for the guard pair that lies past the row's end. The transitions are:
- HEAD to BODY on acceptance of the first pair.
- BODY to BODY on acceptance of each interior pair.
- BODY to TAIL on acceptance of the row's last pair.
- TAIL to HEAD on acceptance of the guard pair, which also advances the row, or wraps it to 0 after the last row.

Top module: `sao_hc_edge_filter`

## Requirements
- R1: For each component, the raw index is 2, plus 1 if the sample is above its left neighbour or minus 1 if below, plus the same term for the right neighbour. Raw indices 0,1,2,3,4 map to categories 1,2,0,3,4. Category k (1..4) selects the signed byte at bits [8k-1:8k-8] of that component's offset word. Category 0 leaves the sample unchanged.
- R2: A component is compared only with the same component of the neighbouring pairs, that is the bytes two positions away in the interleaved row.
- R3: U samples take offsets from `off_u` and V samples take offsets from `off_v`.
- R4: The offset is added to the zero-extended sample, and the sum is clipped to 0..255.
- R5: The left neighbour of a row's first pair is the left-store entry for that row. Once the row's guard pair is accepted, that entry holds the row's last unfiltered pair. Entries of rows outside the block keep their contents.
- R6: When `avail_left` is 0, the first pair of each row leaves unchanged. When `avail_right` is 0, the last pair of each row leaves unchanged.
- R7: Each row is streamed as cfg_width/2 data pairs followed by one guard pair, and the guard pair produces no output. `out_eol` marks a row's last output pair. `out_eob` marks the last output pair of the block's last row.
- R8: During the block's last row, each unfiltered data pair is written to top-store entry equal to its pair index, and is readable through `tb_raddr`.
- R9: On acceptance of a block's first pair, `topleft_u/v` take the top-store entry cfg_width/2-1 as it stood before this block.
- R10: While `out_valid` is high and `out_ready` is low, the output holds stable and `in_ready` is low. With `out_ready` held high, one pair is accepted on every clock.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, and the top-left register and both stores read 0.
- R12: After a row's guard pair, the next accepted pair is treated as the first pair of the following row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | WW | Row width in bytes, a multiple of 8 |
| cfg_height | input | HW | Rows per block |
| avail_left | input | 1 | Left neighbour pair exists |
| avail_right | input | 1 | Right neighbour pair exists |
| off_u | input | 32 | U offsets, category k in byte k-1 |
| off_v | input | 32 | V offsets, category k in byte k-1 |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high with in_valid |
| in_u | input | 8 | Input U sample |
| in_v | input | 8 | Input V sample |
| out_valid | output | 1 | Filtered pair valid |
| out_ready | input | 1 | Downstream accepts the pair |
| out_u | output | 8 | Filtered U |
| out_v | output | 8 | Filtered V |
| out_eol | output | 1 | Last pair of a row |
| out_eob | output | 1 | Last pair of the block |
| lb_we | input | 1 | Left-store load strobe |
| lb_waddr | input | RAW | Left-store load row |
| lb_wdata_u | input | 8 | Left-store load U |
| lb_wdata_v | input | 8 | Left-store load V |
| lb_raddr | input | RAW | Left-store read row |
| lb_rdata_u | output | 8 | Left-store read U |
| lb_rdata_v | output | 8 | Left-store read V |
| tb_raddr | input | TAW | Top-store read pair index |
| tb_rdata_u | output | 8 | Top-store read U |
| tb_rdata_v | output | 8 | Top-store read V |
| topleft_u | output | 8 | Top-left U |
| topleft_v | output | 8 | Top-left V |

## Verification
A filtered pair is registered on the clock edge that accepts its right neighbour. It is therefore due on the output one cycle after that acceptance, and it stays there until a handshake takes it. The row's last pair appears one cycle after the guard pair is accepted. The left-store and top-store entries, and the top-left register, change on the edge that accepts the triggering pair, and their read ports are combinational, so a value written on one edge is visible before the next. The bench pushes each expected pair into a queue before the row is sent and pops one entry on every output handshake sampled at the falling edge, so the checks follow that latency even under random back-pressure; the store read-back checks run only after the output queue has drained.

// File: rtl/sao_hc_pkg.sv
`timescale 1ns/1ps
package sao_hc_pkg;

    localparam int SW   = 8;
    localparam int NCAT = 4;

    typedef struct packed {
        logic [SW-1:0] v;
        logic [SW-1:0] u;
    } cpair_t;

    typedef enum logic [1:0] {
        ST_HEAD = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2
    } phase_t;

    // raw index (local minimum = 0 ... local maximum = 4) to category
    function automatic logic [2:0] remap_cat(input logic [2:0] raw);
        logic [2:0] c;
        case (raw)
            3'd0:    c = 3'd1;
            3'd1:    c = 3'd2;
            3'd2:    c = 3'd0;
            3'd3:    c = 3'd3;
            3'd4:    c = 3'd4;
            default: c = 3'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sao_hc_lane.sv
`timescale 1ns/1ps
module sao_hc_lane
    import sao_hc_pkg::*;
(
    input  logic [SW-1:0]      lft,
    input  logic [SW-1:0]      cur,
    input  logic [SW-1:0]      rgt,
    input  logic [NCAT*SW-1:0] offs,
    input  logic               en,
    output logic [SW-1:0]      res
);

    logic [2:0]    raw;
    logic [2:0]    cat;
    logic [SW-1:0] off;
    logic [SW+1:0] sum;

    always_comb begin
        raw = 3'd2;
        if (cur > lft)      raw = raw + 3'd1;
        else if (cur < lft) raw = raw - 3'd1;
        if (cur > rgt)      raw = raw + 3'd1;
        else if (cur < rgt) raw = raw - 3'd1;

        cat = en ? remap_cat(raw) : 3'd0;

        unique case (cat)
            3'd1:    off = offs[0*SW +: SW];
            3'd2:    off = offs[1*SW +: SW];
            3'd3:    off = offs[2*SW +: SW];
            3'd4:    off = offs[3*SW +: SW];
            default: off = '0;
        endcase

        // signed sum in SW+2 bits: top bit is sign, next bit is overflow
        sum = {2'b00, cur} + {{2{off[SW-1]}}, off};
        if (sum[SW+1])    res = '0;
        else if (sum[SW]) res = '1;
        else              res = sum[SW-1:0];
    end

endmodule

// File: rtl/sao_hc_linestore.sv
`timescale 1ns/1ps
module sao_hc_linestore
    import sao_hc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  cpair_t        wdata,
    input  logic [AW-1:0] ra0,
    output cpair_t        rd0,
    input  logic [AW-1:0] ra1,
    output cpair_t        rd1
);

    cpair_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];

endmodule

// File: rtl/sao_hc_edge_filter.sv
`timescale 1ns/1ps
module sao_hc_edge_filter
    import sao_hc_pkg::*;
#(
    parameter  int MAX_WIDTH  = 64,
    parameter  int MAX_HEIGHT = 64,
    localparam int WW    = $clog2(MAX_WIDTH + 1),
    localparam int HW    = $clog2(MAX_HEIGHT + 1),
    localparam int RAW   = $clog2(MAX_HEIGHT),
    localparam int PAIRS = MAX_WIDTH / 2,
    localparam int TAW   = $clog2(PAIRS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WW-1:0]   cfg_width,
    input  logic [HW-1:0]   cfg_height,
    input  logic            avail_left,
    input  logic            avail_right,
    input  logic [31:0]     off_u,
    input  logic [31:0]     off_v,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_u,
    input  logic [7:0]      in_v,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [7:0]      out_u,
    output logic [7:0]      out_v,
    output logic            out_eol,
    output logic            out_eob,
    input  logic            lb_we,
    input  logic [RAW-1:0]  lb_waddr,
    input  logic [7:0]      lb_wdata_u,
    input  logic [7:0]      lb_wdata_v,
    input  logic [RAW-1:0]  lb_raddr,
    output logic [7:0]      lb_rdata_u,
    output logic [7:0]      lb_rdata_v,
    input  logic [TAW-1:0]  tb_raddr,
    output logic [7:0]      tb_rdata_u,
    output logic [7:0]      tb_rdata_v,
    output logic [7:0]      topleft_u,
    output logic [7:0]      topleft_v
);

    localparam int PW    = WW - 1;
    localparam int LANES = 2;

    phase_t         st_q, st_d;
    logic           acc;
    logic [PW-1:0]  npairs;
    logic [PW-1:0]  col_q;
    logic [RAW-1:0] row_q;
    logic           last_row;
    logic           first_q;
    logic           edge_en;
    cpair_t         lp_q, cp_q, in_pair, tl_q;
    cpair_t         lb_rd_row, lb_rd_ext, tb_rd_last, tb_rd_ext;

    assign in_pair  = cpair_t'({in_v, in_u});
    assign npairs   = PW'(cfg_width >> 1);
    assign last_row = (HW'(row_q) == (cfg_height - HW'(1)));
    assign in_ready = !out_valid || out_ready;
    assign acc      = in_valid && in_ready;

    // ---------------- controller ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HEAD: if (acc) st_d = ST_BODY;
            ST_BODY: if (acc && (col_q == npairs - PW'(1))) st_d = ST_TAIL;
            ST_TAIL: if (acc) st_d = ST_HEAD;
            default: st_d = ST_HEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HEAD;
        else        st_q <= st_d;
    end

    // ---------------- position, delay line, top-left ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            row_q   <= '0;
            lp_q    <= '0;
            cp_q    <= '0;
            first_q <= 1'b0;
            tl_q    <= '0;
        end else if (acc) begin
            unique case (st_q)
                ST_HEAD: begin
                    col_q   <= PW'(1);
                    lp_q    <= lb_rd_row;
                    cp_q    <= in_pair;
                    first_q <= 1'b1;
                    if (row_q == '0) tl_q <= tb_rd_last;
                end
                ST_BODY: begin
                    col_q   <= col_q + PW'(1);
                    lp_q    <= cp_q;
                    cp_q    <= in_pair;
                    first_q <= 1'b0;
                end
                ST_TAIL: begin
                    col_q <= '0;
                    row_q <= last_row ? '0 : row_q + RAW'(1);
                end
                default: col_q <= '0;
            endcase
        end
    end

    // ---------------- edge lanes ----------------
    assign edge_en = (st_q == ST_TAIL) ? avail_right : (first_q ? avail_left : 1'b1);

    logic [LANES-1:0][SW-1:0]      l_a, c_a, r_a, res_a;
    logic [LANES-1:0][NCAT*SW-1:0] o_a;

    assign l_a = {lp_q.v, lp_q.u};
    assign c_a = {cp_q.v, cp_q.u};
    assign r_a = {in_v, in_u};
    assign o_a = {off_v, off_u};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sao_hc_lane u_lane (
            .lft  (l_a[g]),
            .cur  (c_a[g]),
            .rgt  (r_a[g]),
            .offs (o_a[g]),
            .en   (edge_en),
            .res  (res_a[g])
        );
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_u     <= '0;
            out_v     <= '0;
            out_eol   <= 1'b0;
            out_eob   <= 1'b0;
        end else if (acc && (st_q != ST_HEAD)) begin
            out_valid <= 1'b1;
            out_u     <= res_a[0];
            out_v     <= res_a[1];
            out_eol   <= (st_q == ST_TAIL);
            out_eob   <= (st_q == ST_TAIL) && last_row;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // ---------------- neighbour context stores ----------------
    logic   lb_int_we, lb_mux_we;
    logic [RAW-1:0] lb_mux_addr;
    cpair_t lb_mux_data;

    assign lb_int_we   = acc && (st_q == ST_TAIL);
    assign lb_mux_we   = lb_int_we || lb_we;
    assign lb_mux_addr = lb_int_we ? row_q : lb_waddr;
    assign lb_mux_data = lb_int_we ? cp_q : cpair_t'({lb_wdata_v, lb_wdata_u});

    sao_hc_linestore #(.DEPTH(MAX_HEIGHT), .AW(RAW)) u_left (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lb_mux_we),
        .waddr (lb_mux_addr),
        .wdata (lb_mux_data),
        .ra0   (row_q),
        .rd0   (lb_rd_row),
        .ra1   (lb_raddr),
        .rd1   (lb_rd_ext)
    );

    sao_hc_linestore #(.DEPTH(PAIRS), .AW(TAW)) u_top (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc && (st_q != ST_TAIL) && last_row),
        .waddr (col_q[TAW-1:0]),
        .wdata (in_pair),
        .ra0   (TAW'(npairs - PW'(1))),
        .rd0   (tb_rd_last),
        .ra1   (tb_raddr),
        .rd1   (tb_rd_ext)
    );

    assign lb_rdata_u = lb_rd_ext.u;
    assign lb_rdata_v = lb_rd_ext.v;
    assign tb_rdata_u = tb_rd_ext.u;
    assign tb_rdata_v = tb_rd_ext.v;
    assign topleft_u  = tl_q.u;
    assign topleft_v  = tl_q.v;

    // ---------------- assertions ----------------
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_u) && $stable(out_v) && $stable(out_eol))
        else $error("R10: output changed while stalled");

    p_eob_in_eol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eob |-> out_eol)
        else $error("R7: end of block without end of row");

    p_guard_to_head_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TAIL) && acc |=> (st_q == ST_HEAD) && (col_q == '0))
        else $error("R12: guard pair did not restart the row");

    p_right_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TAIL) && acc && !avail_right |=> (out_u == $past(cp_q.u)) && (out_v == $past(cp_q.v)))
        else $error("R6: masked last pair was modified");

    p_head_col_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HEAD) |-> (col_q == '0))
        else $error("R12: row start with nonzero column");

endmodule

// File: tb/sim_sao_hc_edge_filter.sv
`timescale 1ns/1ps
module sim_sao_hc_edge_filter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  cfg_width;
    logic [6:0]  cfg_height;
    logic        avail_left, avail_right;
    logic [31:0] off_u, off_v;
    logic        in_valid, in_ready;
    logic [7:0]  in_u, in_v;
    logic        out_valid, out_ready;
    logic [7:0]  out_u, out_v;
    logic        out_eol, out_eob;
    logic        lb_we;
    logic [5:0]  lb_waddr, lb_raddr;
    logic [7:0]  lb_wdata_u, lb_wdata_v, lb_rdata_u, lb_rdata_v;
    logic [4:0]  tb_raddr;
    logic [7:0]  tb_rdata_u, tb_rdata_v, topleft_u, topleft_v;

    always #10 clk = ~clk;

    sao_hc_edge_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .avail_left(avail_left), .avail_right(avail_right), .off_u(off_u), .off_v(off_v),
        .in_valid(in_valid), .in_ready(in_ready), .in_u(in_u), .in_v(in_v),
        .out_valid(out_valid), .out_ready(out_ready), .out_u(out_u), .out_v(out_v),
        .out_eol(out_eol), .out_eob(out_eob),
        .lb_we(lb_we), .lb_waddr(lb_waddr), .lb_wdata_u(lb_wdata_u), .lb_wdata_v(lb_wdata_v),
        .lb_raddr(lb_raddr), .lb_rdata_u(lb_rdata_u), .lb_rdata_v(lb_rdata_v),
        .tb_raddr(tb_raddr), .tb_rdata_u(tb_rdata_u), .tb_rdata_v(tb_rdata_v),
        .topleft_u(topleft_u), .topleft_v(topleft_v)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit bp_en = 1'b0;

    logic [7:0] qu[$], qv[$];
    bit         qe[$], qb[$];
    string      qt[$];

    logic [7:0] lbm_u[0:63], lbm_v[0:63];
    logic [7:0] tbm_u[0:31], tbm_v[0:31];
    logic [7:0] tlm_u, tlm_v;

    always @(posedge clk) cyc++;

    // back-pressure generator
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && !out_ready) begin
                checks++;
                if (in_ready) begin
                    failures++;
                    $display("FAIL R10 in_ready actual=%0b expected=0 during stall", in_ready);
                end
            end
            if (out_valid && out_ready) begin
                checks++;
                if (qu.size() == 0) begin
                    failures++;
                    $display("FAIL R7 unexpected output actual=%0d/%0d expected=none", out_u, out_v);
                end else begin
                    logic [7:0] eu, ev;
                    bit ee, eb;
                    string tg;
                    eu = qu.pop_front(); ev = qv.pop_front();
                    ee = qe.pop_front(); eb = qb.pop_front(); tg = qt.pop_front();
                    if (out_u !== eu || out_v !== ev || out_eol !== ee || out_eob !== eb) begin
                        failures++;
                        $display("FAIL %s actual=u%0d v%0d eol%0b eob%0b expected=u%0d v%0d eol%0b eob%0b",
                                 tg, out_u, out_v, out_eol, out_eob, eu, ev, ee, eb);
                    end
                end
            end
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    // independent reference of one component
    function automatic logic [7:0] fexp(input int l, input int c, input int r,
                                        input logic [31:0] offs, input bit en,
                                        output bit clipped);
        int cat, o, s;
        cat = 0;
        if (en) begin
            if (c < l && c < r) cat = 1;
            else if ((c < l && c == r) || (c == l && c < r)) cat = 2;
            else if ((c > l && c == r) || (c == l && c > r)) cat = 3;
            else if (c > l && c > r) cat = 4;
        end
        o = (cat == 0) ? 0 : int'($signed(offs[8*cat-8 +: 8]));
        s = c + o;
        clipped = (s < 0) || (s > 255);
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return 8'(s);
    endfunction

    function automatic logic [7:0] rnd();
        logic [7:0] x;
        if (($urandom % 2) != 0) x = 8'($urandom);
        else x = 8'(120 + ($urandom % 3));
        return x;
    endfunction

    task automatic send_pair(input logic [7:0] u, input logic [7:0] v);
        in_valid = 1'b1; in_u = u; in_v = v;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic lb_load(input int r, input logic [7:0] u, input logic [7:0] v);
        @(posedge clk); #1;
        lb_we = 1'b1; lb_waddr = 6'(r); lb_wdata_u = u; lb_wdata_v = v;
        lbm_u[r] = u; lbm_v[r] = v;
        @(posedge clk); #1;
        lb_we = 1'b0;
    endtask

    task automatic chk_lb(input int r);
        @(posedge clk); #1;
        lb_raddr = 6'(r);
        @(negedge clk);
        checks++;
        if (lb_rdata_u !== lbm_u[r] || lb_rdata_v !== lbm_v[r]) begin
            failures++;
            $display("FAIL R5 left row %0d actual=%0d/%0d expected=%0d/%0d",
                     r, lb_rdata_u, lb_rdata_v, lbm_u[r], lbm_v[r]);
        end
    endtask

    task automatic chk_tb(input int c);
        @(posedge clk); #1;
        tb_raddr = 5'(c);
        @(negedge clk);
        checks++;
        if (tb_rdata_u !== tbm_u[c] || tb_rdata_v !== tbm_v[c]) begin
            failures++;
            $display("FAIL R8 top col %0d actual=%0d/%0d expected=%0d/%0d",
                     c, tb_rdata_u, tb_rdata_v, tbm_u[c], tbm_v[c]);
        end
    endtask

    task automatic chk_tl();
        @(negedge clk);
        checks++;
        if (topleft_u !== tlm_u || topleft_v !== tlm_v) begin
            failures++;
            $display("FAIL R9 top-left actual=%0d/%0d expected=%0d/%0d",
                     topleft_u, topleft_v, tlm_u, tlm_v);
        end
    endtask

    task automatic run_block(input int w, input int h, input bit al, input bit ar,
                             input bit craft, input bit bp,
                             input logic [31:0] ou, input logic [31:0] ov,
                             output int cycles);
        int n, t0;
        logic [7:0] pu[0:32], pv[0:32];
        n = w / 2;
        @(posedge clk); #1;
        cfg_width = 7'(w); cfg_height = 7'(h);
        avail_left = al; avail_right = ar; off_u = ou; off_v = ov;
        bp_en = bp;
        tlm_u = tbm_u[n-1]; tlm_v = tbm_v[n-1];
        t0 = cyc;
        for (int r = 0; r < h; r++) begin
            for (int k = 0; k <= n; k++) begin pu[k] = rnd(); pv[k] = rnd(); end
            if (craft && r == 0) begin
                pu[0] = 90;  pu[1] = 120; pu[2] = 120; pu[3] = 110; pu[4] = 130;
                pv[0] = 253; pv[1] = 254; pv[2] = 4;   pv[3] = 10;  pv[4] = 10;
            end
            if (craft && r == 1) begin
                pu[0] = 2; pu[1] = 4; pu[2] = 2; pu[3] = 7; pu[4] = 1;
                for (int k = 0; k <= n; k++) pv[k] = 50;
            end
            for (int k = 0; k < n; k++) begin
                int lu, lv;
                bit en, cu, cv;
                logic [7:0] eu, ev;
                string tg;
                lu = (k == 0) ? int'(lbm_u[r]) : int'(pu[k-1]);
                lv = (k == 0) ? int'(lbm_v[r]) : int'(pv[k-1]);
                en = (k == 0) ? al : ((k == n-1) ? ar : 1'b1);
                eu = fexp(lu, int'(pu[k]), int'(pu[k+1]), ou, en, cu);
                ev = fexp(lv, int'(pv[k]), int'(pv[k+1]), ov, en, cv);
                if (!en) tg = "R6";
                else if (cu || cv) tg = "R4";
                else if (k == 0) tg = "R5";
                else if (k == n-1) tg = "R7 R12";
                else tg = "R1 R2 R3";
                qu.push_back(eu); qv.push_back(ev);
                qe.push_back(k == n-1); qb.push_back((k == n-1) && (r == h-1));
                qt.push_back(tg);
            end
            lbm_u[r] = pu[n-1]; lbm_v[r] = pv[n-1];
            if (r == h-1)
                for (int k = 0; k < n; k++) begin tbm_u[k] = pu[k]; tbm_v[k] = pv[k]; end
            for (int k = 0; k <= n; k++) send_pair(pu[k], pv[k]);
        end
        cycles = cyc - t0;
        while (qu.size() > 0) @(negedge clk);
        bp_en = 1'b0;
    endtask

    initial begin
        int cyc_c;
        rst_n = 1'b0;
        in_valid = 1'b0; in_u = '0; in_v = '0;
        cfg_width = 7'd8; cfg_height = 7'd1;
        avail_left = 1'b1; avail_right = 1'b1; off_u = '0; off_v = '0;
        lb_we = 1'b0; lb_waddr = '0; lb_wdata_u = '0; lb_wdata_v = '0;
        lb_raddr = '0; tb_raddr = '0;
        for (int i = 0; i < 64; i++) begin lbm_u[i] = 0; lbm_v[i] = 0; end
        for (int i = 0; i < 32; i++) begin tbm_u[i] = 0; tbm_v[i] = 0; end
        tlm_u = 0; tlm_v = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: reset state
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1 || topleft_u !== 8'd0 || topleft_v !== 8'd0 ||
            lb_rdata_u !== 8'd0 || tb_rdata_v !== 8'd0) begin
            failures++;
            $display("FAIL R11 reset actual=ov%0b ir%0b tl%0d lb%0d tb%0d expected=ov0 ir1 tl0 lb0 tb0",
                     out_valid, in_ready, topleft_u, lb_rdata_u, tb_rdata_v);
        end

        lb_load(0, 8'd100, 8'd254);
        lb_load(1, 8'd3,   8'd50);
        lb_load(2, 8'd77,  8'd200);
        lb_load(3, 8'd15,  8'd121);

        // Block A: crafted categories and clipping, both edges available
        run_block(8, 3, 1'b1, 1'b1, 1'b1, 1'b0, 32'hF7FD0309, 32'hFAFF0106, cyc_c);
        for (int r = 0; r < 4; r++) chk_lb(r);
        for (int c = 0; c < 4; c++) chk_tb(c);
        chk_tl();

        // Block B: both edges masked, large offsets, back-pressure
        run_block(8, 4, 1'b0, 1'b0, 1'b0, 1'b1, 32'h80F0107F, 32'hE0FE0220, cyc_c);
        chk_tl();
        for (int r = 0; r < 4; r++) chk_lb(r);
        for (int c = 0; c < 4; c++) chk_tb(c);

        // Block C: maximum width, no back-pressure, throughput
        run_block(64, 2, 1'b1, 1'b1, 1'b0, 1'b0, 32'hF7FD0309, 32'hFAFF0106, cyc_c);
        checks++;
        if (cyc_c != 66) begin
            failures++;
            $display("FAIL R10 throughput actual=%0d cycles expected=66", cyc_c);
        end
        chk_tl();
        for (int c = 0; c < 32; c++) chk_tb(c);
        for (int r = 0; r < 2; r++) chk_lb(r);

        // Block D: left available, right masked, back-pressure
        run_block(16, 5, 1'b1, 1'b0, 1'b0, 1'b1, 32'h80F0107F, 32'hE0FE0220, cyc_c);
        chk_tl();
        for (int r = 0; r < 6; r++) chk_lb(r);
        for (int c = 0; c < 8; c++) chk_tb(c);

        repeat (5) @(negedge clk);
        checks++;
        if (qu.size() != 0) begin
            failures++;
            $display("FAIL R7 missing outputs actual=%0d pending expected=0", qu.size());
        end
        report();
        $finish;
    end

endmodule